// File: doc/BRIEF.md
# Outbound Buffer Release Sequencer

This block walks the local source pointers of one outbound DMA instruction once their data has been read. For each pointer it decides whether the buffer behind it goes back to a hardware free pool. When it does, the block emits a release request that carries the pool number and the buffer's start address, aligned to a 128-byte line.

A command names the transfer type, the header's free-local bit, the header's ignore-invert bit and the number of pointers. The pointer words then arrive on a valid/ready stream, at most one per cycle. The release output is a single registered valid/ready stage. A new pointer is taken only when that stage is empty or is being emptied in the same cycle. A zero-size pointer is flagged and skipped. When every pointer of the command has been taken and the last release has been accepted, a one-cycle done pulse marks the end of the command.

Top module: `buf_release_seq`

## Requirements
- R1: After reset, `busy`, `ptrReady`, `relValid`, `sizeErr` and `donePulse` are all low.
- R2: A command is accepted only while `busy` is low. A `startValid` raised while a command is in progress is ignored, and the running command's releases are unchanged.
- R3: Release requests are issued only when the command type is outbound (encoding 0). For inbound (1), internal (2) and external (3), every pointer is still consumed, but no request is issued.
- R4: With the ignore-invert bit set, every non-zero-size pointer of an outbound command is released if free-local is 1, and none is released if free-local is 0.
- R5: With the ignore-invert bit clear, a non-zero-size outbound pointer is released exactly when its invert bit (pointer word bit 49) differs from free-local.
- R6: A release carries the pool from pointer bits 56:54. Its address is ((addr >> 7) - back) << 7, taken modulo 2^36. Here addr is pointer bits 35:0 and back is bits 53:50, so a back-up past zero wraps.
- R7: A pointer whose size field (bits 48:36) is zero produces no release. It raises `sizeErr` for exactly one cycle, in the cycle after the pointer is accepted.
- R8: `ptrReady` is high only while pointers of the current command remain and the release stage is empty or being accepted. A release held under back-pressure keeps its pool and address stable. Releases leave in pointer order.
- R9: Once the commanded count of pointers has been taken and no release is pending, `donePulse` is high for one cycle and `busy` falls in that cycle. A count of zero completes with no pointer taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Command strobe, sampled while idle |
| startType | input | 2 | Transfer type: 0 outbound, 1 inbound, 2 internal, 3 external |
| startFreeLocal | input | 1 | Header free-local bit |
| startIgnoreInv | input | 1 | Header ignore-invert bit |
| startCount | input | CNT_W | Number of pointer words in the command |
| busy | output | 1 | A command is in progress |
| ptrValid | input | 1 | Pointer word present |
| ptrWord | input | 64 | Pointer word |
| ptrReady | output | 1 | Pointer word accepted this cycle when valid |
| relValid | output | 1 | Release request present |
| relReady | input | 1 | Release request taken this cycle when valid |
| relPool | output | 3 | Free pool of the released buffer |
| relAddr | output | 36 | Line-aligned start of the released buffer |
| sizeErr | output | 1 | One-cycle flag for a zero-size pointer |
| donePulse | output | 1 | One-cycle end-of-command pulse |

## Verification
Two things can happen in the same cycle: the release stage hands a request to the sink, and a new pointer is accepted into that same stage. The bench provokes this by keeping `relReady` high while pointers arrive back to back, and it also mixes in sink stalls and source gaps. Each accepted release is compared in order against a list computed arithmetically from the pointer words. A lost or duplicated request in a hand-over cycle shows up as an address mismatch or a wrong release count. The zero-size flag can also coincide with a hand-over, and it is judged separately by its one-cycle delay from the pointer's acceptance.

// File: rtl/buf_release_pkg.sv
package buf_release_pkg;
  localparam int WORD_W     = 64;
  localparam int ADDR_W     = 36;
  localparam int SIZE_LSB   = 36;
  localparam int SIZE_W     = 13;
  localparam int INV_BIT    = 49;
  localparam int BACK_LSB   = 50;
  localparam int BACK_W     = 4;
  localparam int POOL_LSB   = 54;
  localparam int POOL_W     = 3;
  localparam int LINE_SHIFT = 7;
  localparam int LINE_W     = ADDR_W - LINE_SHIFT;

  typedef enum logic [1:0] {
    XFER_OUT    = 2'd0,
    XFER_IN     = 2'd1,
    XFER_LOCAL  = 2'd2,
    XFER_REMOTE = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic takeCmd;
    logic takePtr;
  } seq_strobe_t;

  typedef struct packed {
    logic isOut;
    logic freeLocal;
    logic ignoreInv;
  } rel_mode_t;
endpackage

// File: rtl/buf_release_ctrl.sv
module buf_release_ctrl
  import buf_release_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] startCount,
  input  logic             ptrValid,
  input  logic             relValid,
  input  logic             relReady,
  output seq_strobe_t      strobe,
  output logic             ptrReady,
  output logic             busy,
  output logic             donePulse
);
  seq_state_e       state;
  logic [CNT_W-1:0] remaining;
  logic             outFree;

  assign outFree  = !relValid || relReady;
  assign busy     = (state != ST_IDLE);
  assign ptrReady = (state == ST_RUN) && outFree;

  always_comb begin
    strobe         = '0;
    strobe.takeCmd = (state == ST_IDLE) && startValid;
    strobe.takePtr = ptrReady && ptrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (strobe.takeCmd) begin
            remaining <= startCount;
            state     <= (startCount == '0) ? ST_FLUSH : ST_RUN;
          end
        end
        ST_RUN: begin
          if (strobe.takePtr) begin
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) state <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (outFree) begin
            state     <= ST_IDLE;
            donePulse <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ptrReady |-> busy); // R8
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !relReady) |-> !ptrReady); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R9
  AST_IDLE_NO_REL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !relValid); // R9
endmodule

// File: rtl/buf_release_dp.sv
module buf_release_dp
  import buf_release_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [1:0]        startType,
  input  logic              startFreeLocal,
  input  logic              startIgnoreInv,
  input  logic [WORD_W-1:0] ptrWord,
  input  logic              relReady,
  output logic              relValid,
  output logic [POOL_W-1:0] relPool,
  output logic [ADDR_W-1:0] relAddr,
  output logic              sizeErr
);
  rel_mode_t         mode;
  logic [ADDR_W-1:0] pAddr;
  logic [SIZE_W-1:0] pSize;
  logic              pInv;
  logic [BACK_W-1:0] pBack;
  logic [POOL_W-1:0] pPool;
  logic              sizeZero;
  logic              freeBit;
  logic              wantRel;
  logic [LINE_W-1:0] startLine;

  assign pAddr    = ptrWord[ADDR_W-1:0];
  assign pSize    = ptrWord[SIZE_LSB +: SIZE_W];
  assign pInv     = ptrWord[INV_BIT];
  assign pBack    = ptrWord[BACK_LSB +: BACK_W];
  assign pPool    = ptrWord[POOL_LSB +: POOL_W];
  assign sizeZero = (pSize == '0);

  always_comb begin
    if (mode.ignoreInv) freeBit = mode.freeLocal;
    else                freeBit = mode.freeLocal ^ pInv;
    wantRel   = mode.isOut && freeBit && !sizeZero;
    startLine = pAddr[ADDR_W-1:LINE_SHIFT] - LINE_W'(pBack);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= '0;
      relValid <= 1'b0;
      relPool  <= '0;
      relAddr  <= '0;
      sizeErr  <= 1'b0;
    end else begin
      if (strobe.takeCmd) begin
        mode.isOut     <= (xfer_e'(startType) == XFER_OUT);
        mode.freeLocal <= startFreeLocal;
        mode.ignoreInv <= startIgnoreInv;
      end
      if (relValid && relReady) relValid <= 1'b0;
      if (strobe.takePtr && wantRel) begin
        relValid <= 1'b1;
        relPool  <= pPool;
        relAddr  <= {startLine, {LINE_SHIFT{1'b0}}};
      end
      sizeErr <= strobe.takePtr && sizeZero;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !relReady) |=> (relValid && $stable(relAddr) && $stable(relPool))); // R8
  AST_OUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(relValid) |-> mode.isOut); // R3
  AST_ERR_NO_REL: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr |-> !$rose(relValid)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (sizeErr && !$past(strobe.takePtr)) |-> 1'b0); // R7
endmodule

// File: rtl/buf_release_seq.sv
module buf_release_seq
  import buf_release_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startType,
  input  logic              startFreeLocal,
  input  logic              startIgnoreInv,
  input  logic [CNT_W-1:0]  startCount,
  output logic              busy,
  input  logic              ptrValid,
  input  logic [WORD_W-1:0] ptrWord,
  output logic              ptrReady,
  output logic              relValid,
  input  logic              relReady,
  output logic [POOL_W-1:0] relPool,
  output logic [ADDR_W-1:0] relAddr,
  output logic              sizeErr,
  output logic              donePulse
);
  seq_strobe_t strobe;

  buf_release_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startCount (startCount),
    .ptrValid   (ptrValid),
    .relValid   (relValid),
    .relReady   (relReady),
    .strobe     (strobe),
    .ptrReady   (ptrReady),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  buf_release_dp u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .startType      (startType),
    .startFreeLocal (startFreeLocal),
    .startIgnoreInv (startIgnoreInv),
    .ptrWord        (ptrWord),
    .relReady       (relReady),
    .relValid       (relValid),
    .relPool        (relPool),
    .relAddr        (relAddr),
    .sizeErr        (sizeErr)
  );
endmodule

// File: tb/buf_release_seq_tb.sv
module buf_release_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startValid = 1'b0;
  logic [1:0]       startType = '0;
  logic             startFreeLocal = 1'b0;
  logic             startIgnoreInv = 1'b0;
  logic [CNT_W-1:0] startCount = '0;
  logic             busy;
  logic             ptrValid = 1'b0;
  logic [63:0]      ptrWord = '0;
  logic             ptrReady;
  logic             relValid;
  logic             relReady = 1'b0;
  logic [2:0]       relPool;
  logic [35:0]      relAddr;
  logic             sizeErr;
  logic             donePulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_release_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startType(startType),
    .startFreeLocal(startFreeLocal), .startIgnoreInv(startIgnoreInv),
    .startCount(startCount), .busy(busy), .ptrValid(ptrValid), .ptrWord(ptrWord),
    .ptrReady(ptrReady), .relValid(relValid), .relReady(relReady),
    .relPool(relPool), .relAddr(relAddr), .sizeErr(sizeErr), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] makePtr(input int seed, input int k);
    logic [35:0] a;
    logic [12:0] sz;
    logic [3:0]  bk;
    logic [2:0]  pl;
    logic        inv;
    a   = 36'(longint'(k) * 64'h1234567 + longint'(seed) * 64'h0ABCDE1 + 64'h80_0000_0013);
    bk  = 4'((k * 7 + seed) % 16);
    pl  = 3'((k + seed) % 8);
    inv = 1'(k ^ seed);
    sz  = (k == 3) ? 13'd0 : 13'(k * 37 + 1);
    if (k == 5) begin a = 36'h0_0000_0105; bk = 4'd9; end
    if (k == 6) bk = 4'd15;
    return {7'd0, pl, bk, inv, sz, a};
  endfunction

  task automatic runCmd(input int ty, input int fl, input int ii, input int n,
                        input int rmode, input int seed, input bit noise);
    logic [63:0] ptrs [32];
    logic [35:0] expAddr [32];
    logic [2:0]  expPool [32];
    int expN, expErr, got, errSeen, idx;
    bit prevZero, doneSeen;
    string relTag;
    expN = 0; expErr = 0; got = 0; errSeen = 0; idx = 0;
    prevZero = 0; doneSeen = 0;
    relTag = noise ? "R2" : (ty != 0) ? "R3" : (ii != 0) ? "R4" : "R5";
    for (int k = 0; k < n; k++) begin
      logic [63:0] w;
      bit fr;
      longint unsigned line;
      w = makePtr(seed, k);
      ptrs[k] = w;
      if (w[48:36] == 13'd0) expErr++;
      fr = (ii != 0) ? (fl != 0) : ((fl != 0) != w[49]);
      if (ty == 0 && fr && w[48:36] != 13'd0) begin
        line = (longint'(w[35:0]) >> 7) - longint'(w[53:50]);
        expAddr[expN] = 36'((line << 7) & 64'hF_FFFF_FFFF);
        expPool[expN] = w[56:54];
        expN++;
      end
    end
    @(negedge clk);
    startValid = 1'b1; startType = 2'(ty); startFreeLocal = 1'(fl);
    startIgnoreInv = 1'(ii); startCount = CNT_W'(n);
    @(negedge clk);
    startValid = noise; startType = 2'd0; startFreeLocal = ~1'(fl);
    startIgnoreInv = 1'b1; startCount = CNT_W'(3);
    for (int cyc = 0; cyc < 400; cyc++) begin
      bit took;
      ptrValid = (idx < n) && !(rmode > 0 && cyc % 5 == 3);
      ptrWord  = (idx < n) ? ptrs[idx] : 64'd0;
      relReady = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 2 == 0) : (cyc % 3 == 1);
      if (!(idx < n)) startValid = 1'b0;
      #(CLK_PERIOD/4);
      if (sizeErr || prevZero) begin
        check(sizeErr == prevZero, "R7", sizeErr, prevZero);
        if (sizeErr) errSeen++;
      end
      if (relValid && !relReady) check(!ptrReady, "R8", ptrReady, 0);
      if (relValid && relReady) begin
        if (got < expN) begin
          check(relAddr == expAddr[got], "R6", relAddr, expAddr[got]);
          check(relPool == expPool[got], "R6", relPool, expPool[got]);
        end else begin
          check(1'b0, relTag, got + 1, expN);
        end
        got++;
      end
      if (donePulse) begin
        doneSeen = 1;
        check(!busy, "R9", busy, 0);
        break;
      end
      took = ptrValid && ptrReady;
      prevZero = took && (ptrs[idx][48:36] == 13'd0);
      if (took) idx++;
      @(negedge clk);
    end
    check(got == expN, relTag, got, expN);
    check(errSeen == expErr, "R7", errSeen, expErr);
    check(doneSeen && idx == n, "R9", idx, n);
    ptrValid = 1'b0; relReady = 1'b0; startValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !ptrReady && !relValid && !sizeErr && !donePulse, "R1",
          {busy, ptrReady, relValid, sizeErr, donePulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !relValid && !donePulse, "R1", {busy, relValid, donePulse}, 0);
    for (int ty = 0; ty < 4; ty++)
      for (int fl = 0; fl < 2; fl++)
        for (int ii = 0; ii < 2; ii++)
          for (int rm = 0; rm < 3; rm++)
            runCmd(ty, fl, ii, 9, rm, ty * 12 + fl * 6 + ii * 3 + rm, 1'b0);
    runCmd(0, 1, 0, 0, 0, 5, 1'b0);
    runCmd(0, 1, 1, 31, 0, 2, 1'b0);
    runCmd(0, 0, 0, 31, 2, 7, 1'b0);
    runCmd(0, 1, 0, 8, 1, 4, 1'b1);
    runCmd(0, 0, 1, 8, 0, 9, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule